// File: doc/BRIEF.md
# Direct-Mapped Block Cache with Build-Time Write Policy

This block is a direct-mapped cache controller. It sits between a processor-side word port and a main-memory port that moves one whole block per transfer. Each line stores a valid flag, a dirty flag, a tag and one block of data. A word address is split into three fields. The low bits pick the word inside the block. The next bits pick the line, so the line number is the block address modulo the line count. The remaining high bits form the tag, and only the tag is stored. All lines are invalid after reset.

A build-time parameter selects the write policy.

- **Write-back:** a write hit changes only the line and marks it dirty. A miss whose victim line is valid and dirty first writes the victim block to memory and then fetches the new block.
- **Write-through:** every write updates the line and then sends the updated block to memory. A read miss only fetches.

Both policies allocate on a write miss. The block is fetched first, then the written word is merged into it.

The processor holds its request, direction, address and write data steady until it sees `core_ready`. The memory side holds its request, direction, block address and block data steady until the memory pulses `bus_ack` for one cycle. Read data is driven from the indexed line at all times, before the tag compare has settled. It is only meaningful in a cycle with `core_ready`. A write changes the line only after the tag has matched.

Top module: `dmc_cache`

## Requirements
- R1: With 8 lines and 4 words per block, word address bits [1:0] select the word, bits [4:2] select the line (block address mod 8), and the remaining upper bits are the stored tag. Two blocks whose block addresses differ by a multiple of 8 evict each other, so the first block misses again after the second has been loaded.
- R2: After reset every line is invalid. The first access to any block causes one block read on the memory port, and `core_ready` is low while no request is pending.
- R3: A read that hits asserts `core_ready` in the same cycle as the request, returns the stored word, and causes no memory transfer.
- R4: In write-back mode a write hit completes in the request cycle, updates the cached word, sets the line dirty and leaves main memory unchanged.
- R5: In write-back mode a miss whose victim line is valid and dirty first writes the victim block to the victim's block address (`bus_we`=1), then reads the requested block.
- R6: A fill leaves the line valid and clean. A miss whose victim is invalid or clean performs exactly one block read and no block write.
- R7: A write miss allocates the line: it fetches the block, merges the written word, and in write-back mode leaves the line dirty, so a later eviction writes the merged word to memory.
- R8: In write-through mode every write, hit or miss, ends with a block write carrying the updated word, `core_ready` is given only on that write's acknowledge, and no line ever becomes dirty, so a read miss never writes a victim back.
- R9: `core_ready` stays low throughout any eviction, fill or write-through transfer.
- R10: Once `bus_req` is raised it stays high, with `bus_we`, `bus_baddr` and `bus_wdata` unchanged, until the cycle in which `bus_ack` is high. Each acknowledged transfer moves one full block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Processor request, held until `core_ready` |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Word address |
| core_wdata | input | WORD_W | Write word |
| core_rdata | output | WORD_W | Word of the indexed line, valid with `core_ready` on a read |
| core_ready | output | 1 | Request completes at this clock edge |
| bus_req | output | 1 | Memory transfer request |
| bus_we | output | 1 | 1 = block write, 0 = block read |
| bus_baddr | output | ADDR_W-2 | Block address |
| bus_wdata | output | 4*WORD_W | Block written to memory |
| bus_rdata | input | 4*WORD_W | Block returned by memory, sampled with `bus_ack` |
| bus_ack | input | 1 | One-cycle transfer completion |

## Verification
The assertions check on every cycle that the memory request stays stable until it is acknowledged, and that the processor never sees ready while an eviction or fill is in progress. They also check that an eviction only starts on a valid dirty line, that every fill leaves its line valid and clean, that a write-back write hit produces no memory request, and that no line is ever dirty under write-through. Some behaviours can only be shown by the bench's scenarios, with both policies running against a flat reference memory:
- returned data values;
- line aliasing between blocks eight apart;
- the count and direction of memory transfers per access;
- whether main memory holds the old or the new word after a write hit, and again after a later eviction.

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int WORDS      = 4,
  parameter int LINES      = 8,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    core_req,
  input  logic                    core_we,
  input  logic [ADDR_W-1:0]       core_addr,
  input  logic [WORD_W-1:0]       core_wdata,
  output logic [WORD_W-1:0]       core_rdata,
  output logic                    core_ready,
  output logic                    bus_req,
  output logic                    bus_we,
  output logic [ADDR_W-$clog2(WORDS)-1:0] bus_baddr,
  output logic [WORDS*WORD_W-1:0] bus_wdata,
  input  logic [WORDS*WORD_W-1:0] bus_rdata,
  input  logic                    bus_ack
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int BLK_W = WORDS * WORD_W;

  typedef enum logic [1:0] {S_IDLE, S_EVICT, S_FILL, S_STORE} state_t;
  state_t st;

  logic [BLK_W-1:0] data_q [LINES];
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [LINES-1:0] valid_q, dirty_q;

  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic hit, wr_hit;
  logic [WORDS-1:0][WORD_W-1:0] line_w, merged;

  assign off    = core_addr[OFF_W-1:0];
  assign idx    = core_addr[OFF_W +: IDX_W];
  assign tag    = core_addr[ADDR_W-1 -: TAG_W];
  assign hit    = valid_q[idx] && (tag_q[idx] == tag);
  assign wr_hit = (st == S_IDLE) && core_req && core_we && hit;
  assign line_w = data_q[idx];

  always_comb begin
    merged      = line_w;
    merged[off] = core_wdata;
  end

  assign core_rdata = line_w[off];
  assign core_ready = ((st == S_IDLE) && core_req && hit && (!core_we || WRITE_BACK))
                   || ((st == S_STORE) && bus_ack);

  assign bus_req   = (st != S_IDLE);
  assign bus_we    = (st == S_EVICT) || (st == S_STORE);
  assign bus_baddr = (st == S_EVICT) ? {tag_q[idx], idx} : core_addr[ADDR_W-1:OFF_W];
  assign bus_wdata = data_q[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (core_req) begin
          if (hit) begin
            if (core_we) begin
              if (WRITE_BACK) dirty_q[idx] <= 1'b1;
              else            st <= S_STORE;
            end
          end else if (WRITE_BACK && valid_q[idx] && dirty_q[idx]) begin
            st <= S_EVICT;
          end else begin
            st <= S_FILL;
          end
        end
        S_EVICT: if (bus_ack) st <= S_FILL;
        S_FILL: if (bus_ack) begin
          valid_q[idx] <= 1'b1;
          dirty_q[idx] <= 1'b0;
          st           <= S_IDLE;
        end
        S_STORE: if (bus_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && bus_ack) begin
      data_q[idx] <= bus_rdata;
      tag_q[idx]  <= tag;
    end else if (wr_hit) begin
      data_q[idx] <= merged;
    end
  end

  a_r10_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_baddr) && $stable(bus_wdata));

  a_r9_no_ready_in_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EVICT || st == S_FILL) |-> !core_ready);

  a_r5_evict_dirty_only: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EVICT) |-> valid_q[idx] && dirty_q[idx]);

  a_r6_fill_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL && bus_ack) |=> valid_q[$past(idx)] && !dirty_q[$past(idx)]);

  a_r4_wb_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK && wr_hit) |=> !bus_req);

  a_r8_wt_never_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    !WRITE_BACK |-> (dirty_q == '0));
endmodule

// File: tb/sim_dmc_cache.sv
module sim_mem #(
  parameter int BA_W  = 8,
  parameter int BLK_W = 128,
  parameter int LAT   = 2
) (
  input  logic             clk,
  input  logic             req,
  input  logic             we,
  input  logic [BA_W-1:0]  baddr,
  input  logic [BLK_W-1:0] wdata,
  output logic [BLK_W-1:0] rdata,
  output logic             ack,
  output int               rd_cnt,
  output int               wr_cnt,
  output int               viol
);
  logic [BLK_W-1:0] mem [1<<BA_W];
  int cnt;
  logic pend;
  logic [BA_W-1:0] pend_a;

  initial begin
    for (int b = 0; b < (1<<BA_W); b++)
      for (int w = 0; w < BLK_W/32; w++)
        mem[b][w*32 +: 32] = 32'hC0DE_0000 | (b << 4) | w;
    ack = 0; cnt = 0; rd_cnt = 0; wr_cnt = 0; viol = 0; pend = 0; pend_a = '0;
  end

  assign rdata = mem[baddr];

  always @(posedge clk) begin
    if (pend && (!req || baddr != pend_a)) viol <= viol + 1;
    pend   <= req && !ack;
    pend_a <= baddr;
    if (ack) begin
      ack <= 0;
      cnt <= 0;
      if (we) begin mem[baddr] <= wdata; wr_cnt <= wr_cnt + 1; end
      else rd_cnt <= rd_cnt + 1;
    end else if (req) begin
      if (cnt == LAT) ack <= 1;
      else cnt <= cnt + 1;
    end
  end
endmodule

module sim_dmc_cache;
  localparam int AW = 10;
  localparam int BW = 128;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic        req [2], we [2], ready [2];
  logic [AW-1:0] addr [2];
  logic [31:0] wdata [2], rdata [2];
  logic        breq [2], bwe [2], back [2];
  logic [AW-3:0] bba [2];
  logic [BW-1:0] bwd [2], brd [2];
  int rdc [2], wrc [2], vio [2];
  logic [31:0] refm [2][1<<AW];
  int errors = 0, checks = 0;

  dmc_cache #(.ADDR_W(AW), .WORD_W(32), .WORDS(4), .LINES(8), .WRITE_BACK(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .core_req(req[0]), .core_we(we[0]), .core_addr(addr[0]),
    .core_wdata(wdata[0]), .core_rdata(rdata[0]), .core_ready(ready[0]),
    .bus_req(breq[0]), .bus_we(bwe[0]), .bus_baddr(bba[0]), .bus_wdata(bwd[0]),
    .bus_rdata(brd[0]), .bus_ack(back[0]));
  dmc_cache #(.ADDR_W(AW), .WORD_W(32), .WORDS(4), .LINES(8), .WRITE_BACK(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .core_req(req[1]), .core_we(we[1]), .core_addr(addr[1]),
    .core_wdata(wdata[1]), .core_rdata(rdata[1]), .core_ready(ready[1]),
    .bus_req(breq[1]), .bus_we(bwe[1]), .bus_baddr(bba[1]), .bus_wdata(bwd[1]),
    .bus_rdata(brd[1]), .bus_ack(back[1]));

  sim_mem #(.BA_W(AW-2), .BLK_W(BW), .LAT(2)) m0 (.clk(clk), .req(breq[0]), .we(bwe[0]),
    .baddr(bba[0]), .wdata(bwd[0]), .rdata(brd[0]), .ack(back[0]),
    .rd_cnt(rdc[0]), .wr_cnt(wrc[0]), .viol(vio[0]));
  sim_mem #(.BA_W(AW-2), .BLK_W(BW), .LAT(2)) m1 (.clk(clk), .req(breq[1]), .we(bwe[1]),
    .baddr(bba[1]), .wdata(bwd[1]), .rdata(brd[1]), .ack(back[1]),
    .rd_cnt(rdc[1]), .wr_cnt(wrc[1]), .viol(vio[1]));

  function automatic int B(input int blk, input int w);
    return blk * 4 + w;
  endfunction

  function automatic logic [31:0] memword(input int p, input int a);
    if (p == 0) return m0.mem[a >> 2][(a & 3)*32 +: 32];
    return m1.mem[a >> 2][(a & 3)*32 +: 32];
  endfunction

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic op(input int p, input bit w, input int a, input logic [31:0] d,
                    input int exp_rd, input int exp_wr, input string r);
    int r0, w0, cyc;
    logic [31:0] q;
    r0 = rdc[p]; w0 = wrc[p];
    @(negedge clk);
    req[p] = 1; we[p] = w; addr[p] = a[AW-1:0]; wdata[p] = d;
    #1; cyc = 0;
    while (!ready[p]) begin @(negedge clk); #1; cyc++; end
    q = rdata[p];
    @(negedge clk);
    req[p] = 0; we[p] = 0;
    if (w) refm[p][a] = d;
    else chk(r, "read data", q, refm[p][a]);
    chk(r, "block reads", rdc[p] - r0, exp_rd);
    chk(r, "block writes", wrc[p] - w0, exp_wr);
    if (exp_rd + exp_wr == 0 && w && p == 1) ;
    else if (exp_rd + exp_wr == 0) chk(r, "hit latency", cyc, 0);
    else chk("R9", "ready held low cycles", cyc >= 3 * (exp_rd + exp_wr), 1);
  endtask

  task automatic t_reset();
    chk("R2", "ready idle wb", ready[0], 0);
    chk("R2", "ready idle wt", ready[1], 0);
    chk("R2", "bus_req idle", breq[0] | breq[1], 0);
  endtask

  task automatic t_wb_lookup();
    op(0, 0, B(12,1), 0, 1, 0, "R2");
    op(0, 0, B(12,2), 0, 0, 0, "R3");
    op(0, 0, B(4,0),  0, 1, 0, "R1");
    op(0, 0, B(12,0), 0, 1, 0, "R1");
  endtask

  task automatic t_wb_dirty();
    op(0, 1, B(12,3), 32'h1111_2222, 0, 0, "R4");
    op(0, 0, B(12,3), 0, 0, 0, "R4");
    chk("R4", "memory untouched", memword(0, B(12,3)), 32'hC0DE_0000 | (12 << 4) | 3);
    op(0, 0, B(20,0), 0, 1, 1, "R5");
    chk("R5", "victim written back", memword(0, B(12,3)), 32'h1111_2222);
  endtask

  task automatic t_wb_alloc();
    op(0, 1, B(29,2), 32'h3333_4444, 1, 0, "R7");
    op(0, 0, B(29,2), 0, 0, 0, "R7");
    op(0, 0, B(37,1), 0, 1, 1, "R7");
    chk("R7", "merged word evicted", memword(0, B(29,2)), 32'h3333_4444);
    op(0, 0, B(6,0),  0, 1, 0, "R6");
    op(0, 0, B(14,0), 0, 1, 0, "R6");
  endtask

  task automatic t_wt();
    op(1, 0, B(12,0), 0, 1, 0, "R2");
    op(1, 1, B(12,1), 32'h5555_6666, 0, 1, "R8");
    chk("R8", "memory updated on hit", memword(1, B(12,1)), 32'h5555_6666);
    op(1, 0, B(12,1), 0, 0, 0, "R8");
    op(1, 0, B(4,0),  0, 1, 0, "R8");
    op(1, 1, B(27,3), 32'h7777_8888, 1, 1, "R8");
    chk("R8", "memory updated on miss", memword(1, B(27,3)), 32'h7777_8888);
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      req[p] = 0; we[p] = 0; addr[p] = '0; wdata[p] = '0;
      for (int a = 0; a < (1<<AW); a++) refm[p][a] = 32'hC0DE_0000 | ((a >> 2) << 4) | (a & 3);
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_wb_lookup();
    t_wb_dirty();
    t_wb_alloc();
    t_wt();
    chk("R10", "handshake violations", vio[0] + vio[1], 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule